// File: doc/BRIEF.md
# Byte-to-Halfword Dual-Clock FIFO

This block carries a stream of bytes from one clock domain into another and delivers it there as 16-bit halfwords. The producer presents one byte per write-clock cycle with a write request. The block stores the bytes in pairs. The first byte of each pair becomes the low half of a halfword, and the second byte becomes the high half. The consumer, running on an unrelated read clock, pulls whole halfwords with a read request.

Each domain keeps its own binary pointer. A Gray-coded copy of each pointer is passed to the other domain through a two-flop synchronizer. Each side then works out its own status from its own pointer and the synchronized copy of the other pointer:
- The write side produces a full flag and a count of stored bytes.
- The read side produces an empty flag and a count of complete halfwords.

A byte that is still waiting for its partner is counted on the write side. It stays invisible to the reader, which sees the FIFO as empty until the pair is complete.

Top module: `pack_cdc_fifo`

## Requirements
- R1: The write port takes 8-bit data and the read port returns 16-bit data. Of each pair of bytes, the first one accepted appears in bits [7:0] of the halfword and the second in bits [15:8].
- R2: `rd_empty` stays high while fewer than two bytes are stored beyond the halfwords already read. A single unpaired byte never makes a halfword readable.
- R3: After four bytes are written into an empty FIFO, two accepted reads return it to empty, with `rd_empty` high and both counts at zero once the pointers have crossed.
- R4: Read data is registered. `rd_data` changes on the first rising read-clock edge that accepts a read request, not earlier.
- R5: A read request while `rd_empty` is high is ignored. `rd_data` holds its value, `rd_used` stays 0, and the next halfword written is still the next one read.
- R6: `wr_full` is high when 2×2^(USED_W-2) bytes are stored (16 by default). A write request while `wr_full` is high is ignored, and `wr_used` does not rise.
- R7: `wr_used` counts the bytes stored, including an unpaired byte. `rd_used` counts the complete halfwords readable. Both ports are USED_W bits wide.
- R8: Each pointer crosses the clock boundary in Gray code. Each Gray pointer register changes by at most one bit per clock.
- R9: While the active-low resets are low, the pointers, the pairing state and the counts clear. After reset, `rd_empty` is 1, `wr_full` is 0 and both counts are 0.
- R10: Byte order is preserved across pointer wrap-around and while writes and reads run at the same time on their separate clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 8 | Byte to store |
| wr_full | output | 1 | No room for another byte |
| wr_used | output | USED_W | Bytes stored, as seen from the write side |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain synchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_data | output | 16 | Registered halfword |
| rd_empty | output | 1 | No complete halfword available |
| rd_used | output | USED_W | Complete halfwords available, as seen from the read side |

## Verification
The tests are arranged to separate specific faults:
- **Single byte, then its partner:** shows whether pairing gates visibility. A lone byte must keep the FIFO empty.
- **Distinct byte values:** expose a swapped half, meaning packing in the wrong byte order.
- **Reads while empty, followed by a fresh pair:** tell apart a read that is truly ignored from one that silently advances the read pointer.
- **Fill to capacity, then two extra writes:** detect a full flag that lets data through. The extra bytes would show up as a count change or as corrupted order.
- **Repeated rounds and concurrent streaming:** wrap both pointers while the clocks run at unrelated rates, which checks ordering across the crossing.

// File: rtl/pack_cdc_pkg.sv
// Shared helpers for the byte-to-halfword dual-clock FIFO.
// Assumes pointer widths of at most 32 bits.
package pack_cdc_pkg;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/pcf_sync2.sv
// Two-flop synchronizer for a Gray-coded pointer.
// Assumes the source changes at most one bit per source clock.
module pcf_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Capture the foreign pointer, then settle it one stage further.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/pcf_ram.sv
// Halfword storage: one write port on the write clock, one
// asynchronous read port. The reader registers the output.
module pcf_ram #(
    parameter int AW = 3,
    parameter int DW = 16
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store a completed halfword.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pcf_wr_side.sv
// Write-domain control. Holds the first byte of a pair, then writes
// the completed halfword (first byte low). Keeps a byte-granular
// pointer whose upper bits form the halfword pointer exported in Gray.
// Assumes rd_gray_s is already synchronized into wr_clk.
module pcf_wr_side
    import pack_cdc_pkg::*;
#(
    parameter int USED_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [USED_W-2:0] rd_gray_s,
    output logic [USED_W-2:0] wr_gray,
    output logic              full,
    output logic [USED_W-1:0] used,
    output logic              ram_we,
    output logic [USED_W-3:0] ram_addr,
    output logic [HALF_W-1:0] ram_wdata
);
    localparam int PW = USED_W - 1;                 // halfword pointer width
    localparam logic [USED_W-1:0] CAP = USED_W'(1) << (USED_W - 1);

    logic [USED_W-1:0] bptr_q;
    logic [BYTE_W-1:0] low_q;
    logic [PW-1:0]     rd_bin;
    logic              accept;
    logic [USED_W-1:0] bptr_nxt;

    assign rd_bin   = PW'(from_gray(32'(rd_gray_s)));
    assign used     = bptr_q - {rd_bin, 1'b0};
    assign full     = (used == CAP);
    assign accept   = wr_en && !full;
    assign bptr_nxt = bptr_q + USED_W'(accept);

    assign ram_we    = accept && bptr_q[0];
    assign ram_addr  = bptr_q[USED_W-2:1];
    assign ram_wdata = {wr_data, low_q};

    // Advance the byte pointer and latch the low byte of a pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bptr_q  <= '0;
            low_q   <= '0;
            wr_gray <= '0;
        end else begin
            bptr_q  <= bptr_nxt;
            wr_gray <= PW'(to_gray(32'(bptr_nxt[USED_W-1:1])));
            if (accept && !bptr_q[0]) low_q <= wr_data;
        end
    end
endmodule

// File: rtl/pcf_rd_side.sv
// Read-domain control. Compares its halfword pointer with the
// synchronized write pointer and registers the output on each
// accepted read. Assumes wr_gray_s is already in rd_clk.
module pcf_rd_side
    import pack_cdc_pkg::*;
#(
    parameter int USED_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [USED_W-2:0] wr_gray_s,
    input  logic [HALF_W-1:0] ram_rdata,
    output logic [USED_W-3:0] ram_addr,
    output logic [USED_W-2:0] rd_gray,
    output logic [HALF_W-1:0] rd_data,
    output logic              empty,
    output logic [USED_W-1:0] used
);
    localparam int PW = USED_W - 1;

    logic [PW-1:0] hptr_q;
    logic [PW-1:0] wr_bin;
    logic [PW-1:0] avail;
    logic          accept;
    logic [PW-1:0] hptr_nxt;

    assign wr_bin   = PW'(from_gray(32'(wr_gray_s)));
    assign avail    = wr_bin - hptr_q;
    assign empty    = (avail == '0);
    assign used     = {1'b0, avail};
    assign accept   = rd_en && !empty;
    assign hptr_nxt = hptr_q + PW'(accept);
    assign ram_addr = hptr_q[PW-2:0];

    // Advance the read pointer and register the halfword.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hptr_q  <= '0;
            rd_gray <= '0;
            rd_data <= '0;
        end else begin
            hptr_q  <= hptr_nxt;
            rd_gray <= PW'(to_gray(32'(hptr_nxt)));
            if (accept) rd_data <= ram_rdata;
        end
    end
endmodule

// File: rtl/pack_cdc_fifo.sv
// Byte-in, halfword-out FIFO between two unrelated clocks.
// Capacity is 2^(USED_W-2) halfwords. Each Gray pointer crosses
// through a two-flop synchronizer. Both resets are synchronous, active-low.
module pack_cdc_fifo
    import pack_cdc_pkg::*;
#(
    parameter int USED_W = 5
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic              wr_full,
    output logic [USED_W-1:0] wr_used,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [15:0]       rd_data,
    output logic              rd_empty,
    output logic [USED_W-1:0] rd_used
);
    localparam int PW = USED_W - 1;
    localparam int AW = USED_W - 2;

    logic [PW-1:0]     wgray_w, wgray_r, rgray_r, rgray_w;
    logic              ram_we;
    logic [AW-1:0]     ram_waddr, ram_raddr;
    logic [HALF_W-1:0] ram_wdata, ram_rdata;

    pcf_wr_side #(.USED_W(USED_W)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_gray_s(rgray_w), .wr_gray(wgray_w), .full(wr_full), .used(wr_used),
        .ram_we(ram_we), .ram_addr(ram_waddr), .ram_wdata(ram_wdata)
    );

    pcf_sync2 #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray_w), .q(wgray_r)
    );

    pcf_sync2 #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray_r), .q(rgray_w)
    );

    pcf_ram #(.AW(AW), .DW(HALF_W)) u_ram (
        .wclk(wr_clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    pcf_rd_side #(.USED_W(USED_W)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wr_gray_s(wgray_r),
        .ram_rdata(ram_rdata), .ram_addr(ram_raddr), .rd_gray(rgray_r),
        .rd_data(rd_data), .empty(rd_empty), .used(rd_used)
    );
endmodule

// File: rtl/pack_cdc_fifo_chk.sv
// Property checker for pack_cdc_fifo, attached by bind below.
module pack_cdc_fifo_chk #(
    parameter int USED_W = 5
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_en,
    input logic              wr_full,
    input logic [USED_W-1:0] wr_used,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_en,
    input logic [15:0]       rd_data,
    input logic              rd_empty,
    input logic [USED_W-1:0] rd_used,
    input logic [USED_W-2:0] wgray,
    input logic [USED_W-2:0] rgray
);
    localparam logic [USED_W:0] BYTE_CAP = (USED_W+1)'(1) << (USED_W - 1);

    // R6
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_full && wr_en) |=> ({1'b0, wr_used} <= {1'b0, $past(wr_used)}));

    // R6
    used_cap_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        ({1'b0, wr_used} <= BYTE_CAP));

    // R7
    used_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        ({1'b0, wr_used} <= {1'b0, $past(wr_used)} + (USED_W+1)'(1)));

    // R7
    idle_no_grow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_en |=> ({1'b0, wr_used} <= {1'b0, $past(wr_used)}));

    // R5
    empty_read_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_empty && rd_en) |=> $stable(rd_data));

    // R4
    idle_read_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_en |=> $stable(rd_data));

    // R8
    wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $onehot0(wgray ^ $past(wgray)));

    // R8
    rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $onehot0(rgray ^ $past(rgray)));
endmodule

bind pack_cdc_fifo pack_cdc_fifo_chk #(.USED_W(USED_W)) u_chk (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_full(wr_full),
    .wr_used(wr_used), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .rd_data(rd_data), .rd_empty(rd_empty), .rd_used(rd_used),
    .wgray(wgray_w), .rgray(rgray_r)
);

// File: tb/pack_cdc_fifo_test.sv
module pack_cdc_fifo_test;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int USED_W     = 5;
    localparam int CAP_BYTES  = 1 << (USED_W - 1);

    logic              wr_clk = 0, rd_clk = 0;
    logic              wr_rst_n = 0, rd_rst_n = 0;
    logic              wr_en = 0, rd_en = 0;
    logic [7:0]        wr_data = 0;
    logic              wr_full, rd_empty;
    logic [15:0]       rd_data;
    logic [USED_W-1:0] wr_used, rd_used;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] model[$];

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

    pack_cdc_fifo #(.USED_W(USED_W)) uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_used(wr_used), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .rd_en(rd_en), .rd_data(rd_data), .rd_empty(rd_empty), .rd_used(rd_used)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge wr_clk);
        while (wr_full) @(negedge wr_clk);
        wr_en = 1; wr_data = b; model.push_back(b);
        @(negedge wr_clk);
        wr_en = 0;
    endtask

    task automatic rd_word(input string req);
        logic [15:0] exp;
        @(negedge rd_clk);
        while (rd_empty) @(negedge rd_clk);
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
        exp = {model[1], model[0]};
        void'(model.pop_front()); void'(model.pop_front());
        chk(req, 32'(rd_data), 32'(exp));
    endtask

    // R9: state straight after reset
    task automatic t_reset();
        chk("R9 empty", 32'(rd_empty), 1);
        chk("R9 full", 32'(wr_full), 0);
        chk("R9 wr_used", 32'(wr_used), 0);
        chk("R9 rd_used", 32'(rd_used), 0);
    endtask

    // R2, R7, R1, R4: lone byte stays hidden; pair reads back low-first
    task automatic t_pairing();
        wr_byte(8'h11);
        settle();
        chk("R2 lone byte empty", 32'(rd_empty), 1);
        chk("R7 wr_used lone", 32'(wr_used), 1);
        chk("R7 rd_used lone", 32'(rd_used), 0);
        wr_byte(8'h22);
        settle();
        chk("R2 pair visible", 32'(rd_empty), 0);
        chk("R7 rd_used pair", 32'(rd_used), 1);
        chk("R7 wr_used pair", 32'(wr_used), 2);
        @(negedge rd_clk);
        rd_en = 1;
        chk("R4 data before edge", 32'(rd_data), 0);
        @(negedge rd_clk);
        rd_en = 0;
        chk("R1 R4 low-first word", 32'(rd_data), 32'h2211);
        void'(model.pop_front()); void'(model.pop_front());
    endtask

    // R3: four byte writes, two reads, back to empty
    task automatic t_four_two();
        wr_byte(8'hAA); wr_byte(8'hBB); wr_byte(8'hCC); wr_byte(8'hDD);
        settle();
        chk("R3 rd_used two", 32'(rd_used), 2);
        rd_word("R3 first");
        rd_word("R3 second");
        settle();
        chk("R3 empty again", 32'(rd_empty), 1);
        chk("R3 rd_used zero", 32'(rd_used), 0);
        chk("R3 wr_used zero", 32'(wr_used), 0);
    endtask

    // R5: reads while empty are ignored
    task automatic t_read_empty();
        @(negedge rd_clk);
        rd_en = 1;
        repeat (3) @(negedge rd_clk);
        rd_en = 0;
        chk("R5 data held", 32'(rd_data), 32'hDDCC);
        chk("R5 rd_used", 32'(rd_used), 0);
        chk("R5 still empty", 32'(rd_empty), 1);
        wr_byte(8'h5A); wr_byte(8'hA5);
        rd_word("R5 pointer not advanced");
    endtask

    // R6: fill to capacity; writes while full are dropped
    task automatic t_full();
        settle();
        for (int i = 0; i < CAP_BYTES; i++) wr_byte(8'(i * 7 + 3));
        @(negedge wr_clk);
        chk("R6 full flag", 32'(wr_full), 1);
        chk("R6 wr_used cap", 32'(wr_used), CAP_BYTES);
        wr_en = 1; wr_data = 8'hEE;
        @(negedge wr_clk);
        wr_data = 8'hEF;
        @(negedge wr_clk);
        wr_en = 0;
        chk("R6 wr_used unchanged", 32'(wr_used), CAP_BYTES);
        for (int i = 0; i < CAP_BYTES / 2; i++) rd_word("R6 drain order");
        settle();
        chk("R6 empty after drain", 32'(rd_empty), 1);
        chk("R6 no extra bytes", 32'(wr_used), 0);
    endtask

    // R10: rounds across wrap, then concurrent streaming
    task automatic t_wrap();
        for (int r = 0; r < 5; r++) begin
            for (int i = 0; i < 6; i++) wr_byte(8'(8'h40 + r * 16 + i));
            for (int i = 0; i < 3; i++) rd_word("R10 round order");
        end
        fork
            for (int i = 0; i < 40; i++) wr_byte(8'(8'h90 + i));
            for (int i = 0; i < 20; i++) rd_word("R10 streaming order");
        join
        settle();
        chk("R10 empty at end", 32'(rd_empty), 1);
    endtask

    initial begin
        repeat (4) @(negedge rd_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        @(negedge wr_clk);
        t_reset();
        t_pairing();
        t_four_two();
        t_read_empty();
        t_full();
        t_wrap();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge wr_clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule